// File: doc/BRIEF.md
# Dual-Port Byte-Lane Synchronous RAM

This block is a shared memory with two fully independent synchronous ports, A and B. Each port has its own clock, address, write data, read data, read/write control and output enable. Each port also has a pair of chip enables of opposite polarity and an active-low select for each byte lane. Either port can reach any word at any time, including the word the other port is using. Storage is split into 8-bit lanes, so a port can write or read the upper byte, the lower byte or both.

Each port has a mode input that sets its read latency. With flow-through, data for an address sampled at a rising edge is presented during the cycle that follows. With pipelined, the data arrives one edge later. Tri-state drive is replaced by a per-lane valid flag. A lane's read data register keeps its last value until that lane is read again. The output enable gates the valid flags combinationally. Every other control is sampled on the port's own rising clock edge.

Top module: `dual_port_lane_ram`

## Requirements
- R1: A port is selected only when its ce0_n is 0 and its ce1 is 1. Any other pair makes that edge a no-operation: nothing is written, and the port's flow-through rvalid is 00 after that edge.
- R2: A selected port with wr_n = 0 writes at the rising edge. ub_n = 0 enables the upper lane (bits 15:8) and lb_n = 0 enables the lower lane (bits 7:0). A lane whose select is 1 keeps its stored byte.
- R3: A selected port with wr_n = 1 reads. Flag rvalid[1] belongs to the upper lane and rvalid[0] to the lower lane. A flag can be set only for a lane whose select was 0 at the read edge. A write edge leaves the flow-through flags at 00.
- R4: With pipe = 0, the word at the address sampled at edge k appears on rdata with its flags after edge k and stays until edge k+1.
- R5: With pipe = 1, the same result appears after edge k+1 instead. Its flags are set only if the port is also selected at edge k+1, so a deselected port needs two consecutive selected edges before it drives again.
- R6: oe_n = 1 forces rvalid to 00 immediately, without a clock edge. It changes neither storage nor the read pipeline, so lowering oe_n again restores the flags at once.
- R7: Both ports can access any address on the same edge. When one port writes a word and the other reads it on the same edge, the read returns the value held before that edge. The new value is readable from the next edge on.
- R8: A lane that is not read at an edge keeps its previous value on rdata.
- R9: While rst_n is 0, rvalid and rdata of both ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| b_clk | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_ce0_n | input | 1 | Port A enable, active low |
| a_ce1 | input | 1 | Port A enable, active high |
| a_wr_n | input | 1 | Port A write (0) or read (1) |
| a_ub_n | input | 1 | Port A upper lane select, active low |
| a_lb_n | input | 1 | Port A lower lane select, active low |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_pipe | input | 1 | Port A read latency: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_rvalid | output | DATA_W/8 | Port A per-lane read valid flags |
| b_ce0_n | input | 1 | Port B enable, active low |
| b_ce1 | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B write (0) or read (1) |
| b_ub_n | input | 1 | Port B upper lane select, active low |
| b_lb_n | input | 1 | Port B lower lane select, active low |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_pipe | input | 1 | Port B read latency: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | DATA_W/8 | Port B per-lane read valid flags |

## Verification
Some rules can be checked on every edge from a port's own pins, and the assertions cover these. They check that a deselect or a write clears the flags, that a lane whose select was high stays invalid, that a raised output enable forces the flags low, that a pipelined flag requires a select on the previous edge, and that a lane register holds while it is not read. Stored contents cannot be judged from one port alone. Lane-masked writes, read-before-write on a shared word and data landing at the correct latency in each mode are shown only by the bench's reference memory, which is compared with both ports every cycle during directed and random traffic.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int LANE_W = 8;

    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rd_mode_e;

    function automatic logic port_selected(input logic ce_lo_n, input logic ce_hi);
        return (!ce_lo_n) && ce_hi;
    endfunction
endpackage

// File: rtl/dpr_lane_bank.sv
module dpr_lane_bank #(
    parameter int ADDR_W = 10,
    parameter int LW     = dpr_pkg::LANE_W
) (
    input  logic              rst_n,
    input  logic              clk_a,
    input  logic              we_a,
    input  logic              re_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [LW-1:0]     wd_a,
    output logic [LW-1:0]     rd_a,
    input  logic              clk_b,
    input  logic              we_b,
    input  logic              re_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [LW-1:0]     wd_b,
    output logic [LW-1:0]     rd_b
);
    localparam int DEPTH = 1 << ADDR_W;

    // Each port owns one bank; the stored byte is the XOR of both banks.
    logic [LW-1:0] bank_a [DEPTH];
    logic [LW-1:0] bank_b [DEPTH];
    logic [LW-1:0] rd_a_q, rd_b_q;

    always_ff @(posedge clk_a) begin
        if (we_a) bank_a[addr_a] <= wd_a ^ bank_b[addr_a];
    end

    always_ff @(posedge clk_b) begin
        if (we_b) bank_b[addr_b] <= wd_b ^ bank_a[addr_b];
    end

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n)    rd_a_q <= '0;
        else if (re_a) rd_a_q <= bank_a[addr_a] ^ bank_b[addr_a];
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n)    rd_b_q <= '0;
        else if (re_b) rd_b_q <= bank_a[addr_b] ^ bank_b[addr_b];
    end

    assign rd_a = rd_a_q;
    assign rd_b = rd_b_q;

    assert_hold_a_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
        !re_a |=> $stable(rd_a));
    assert_hold_b_R8: assert property (@(posedge clk_b) disable iff (!rst_n)
        !re_b |=> $stable(rd_b));
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / dpr_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              wr_n,
    input  logic [LANES-1:0]  be_n,
    input  logic              oe_n,
    input  logic              mode,
    input  logic [DATA_W-1:0] lane_rd,
    output logic [LANES-1:0]  wr_lane,
    output logic [LANES-1:0]  rd_lane,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  rvalid
);
    import dpr_pkg::*;

    typedef struct packed {
        logic [LANES-1:0]  s1_v;
        logic [LANES-1:0]  s2_v;
        logic [DATA_W-1:0] s2_d;
    } port_state_t;

    port_state_t st_d, st_q;
    logic        sel;
    rd_mode_e    rmode;

    assign sel   = port_selected(ce0_n, ce1);
    assign rmode = rd_mode_e'(mode);

    assign wr_lane = {LANES{sel && !wr_n}} & ~be_n;
    assign rd_lane = {LANES{sel &&  wr_n}} & ~be_n;

    always_comb begin
        st_d      = st_q;
        st_d.s1_v = rd_lane;
        // The second stage also needs the chip selected at the edge it is loaded.
        st_d.s2_v = st_q.s1_v & {LANES{sel}};
        st_d.s2_d = lane_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (rmode == RD_PIPE) begin
            rdata  = st_q.s2_d;
            rvalid = st_q.s2_v & {LANES{!oe_n}};
        end else begin
            rdata  = lane_rd;
            rvalid = st_q.s1_v & {LANES{!oe_n}};
        end
    end

    assert_deselect_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (rvalid == '0));
    assert_write_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_n) |=> (mode || rvalid == '0));
    assert_lane_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_n) |=> (mode || (rvalid & $past(be_n)) == '0));
    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (rvalid == '0));
    assert_pipe_two_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && rvalid != '0) |-> $past(sel));
endmodule

// File: rtl/dual_port_lane_ram.sv
module dual_port_lane_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / dpr_pkg::LANE_W
) (
    input  logic              a_clk,
    input  logic              b_clk,
    input  logic              rst_n,
    input  logic              a_ce0_n,
    input  logic              a_ce1,
    input  logic              a_wr_n,
    input  logic              a_ub_n,
    input  logic              a_lb_n,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic [LANES-1:0]  a_rvalid,
    input  logic              b_ce0_n,
    input  logic              b_ce1,
    input  logic              b_wr_n,
    input  logic              b_ub_n,
    input  logic              b_lb_n,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic [LANES-1:0]  b_rvalid
);
    localparam int LW = dpr_pkg::LANE_W;

    logic [LANES-1:0]  a_be_n, b_be_n;
    logic [LANES-1:0]  a_wr_lane, a_rd_lane, b_wr_lane, b_rd_lane;
    logic [DATA_W-1:0] a_lane_rd, b_lane_rd;

    // Upper select covers the top half of the lanes, lower select the bottom half.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_be
            if (l >= LANES / 2) begin : g_hi
                assign a_be_n[l] = a_ub_n;
                assign b_be_n[l] = b_ub_n;
            end else begin : g_lo
                assign a_be_n[l] = a_lb_n;
                assign b_be_n[l] = b_lb_n;
            end
        end
    endgenerate

    dpr_port #(.DATA_W(DATA_W), .LANES(LANES)) u_port_a (
        .clk(a_clk), .rst_n(rst_n), .ce0_n(a_ce0_n), .ce1(a_ce1), .wr_n(a_wr_n),
        .be_n(a_be_n), .oe_n(a_oe_n), .mode(a_pipe), .lane_rd(a_lane_rd),
        .wr_lane(a_wr_lane), .rd_lane(a_rd_lane), .rdata(a_rdata), .rvalid(a_rvalid)
    );

    dpr_port #(.DATA_W(DATA_W), .LANES(LANES)) u_port_b (
        .clk(b_clk), .rst_n(rst_n), .ce0_n(b_ce0_n), .ce1(b_ce1), .wr_n(b_wr_n),
        .be_n(b_be_n), .oe_n(b_oe_n), .mode(b_pipe), .lane_rd(b_lane_rd),
        .wr_lane(b_wr_lane), .rd_lane(b_rd_lane), .rdata(b_rdata), .rvalid(b_rvalid)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            dpr_lane_bank #(.ADDR_W(ADDR_W), .LW(LW)) u_bank (
                .rst_n (rst_n),
                .clk_a (a_clk),
                .we_a  (a_wr_lane[l]),
                .re_a  (a_rd_lane[l]),
                .addr_a(a_addr),
                .wd_a  (a_wdata[l*LW +: LW]),
                .rd_a  (a_lane_rd[l*LW +: LW]),
                .clk_b (b_clk),
                .we_b  (b_wr_lane[l]),
                .re_b  (b_rd_lane[l]),
                .addr_b(b_addr),
                .wd_b  (b_wdata[l*LW +: LW]),
                .rd_b  (b_lane_rd[l*LW +: LW])
            );
        end
    endgenerate
endmodule

// File: tb/tb_dual_port_lane_ram.sv
module tb_dual_port_lane_ram;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          ce0_n [2];
    logic          ce1   [2];
    logic          wr_n  [2];
    logic          ub_n  [2];
    logic          lb_n  [2];
    logic          oe_n  [2];
    logic          pipe  [2];
    logic [AW-1:0] addr  [2];
    logic [DW-1:0] wdata [2];
    logic [DW-1:0] rdata [2];
    logic [1:0]    rvalid[2];

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] ft_d [2];
    logic [DW-1:0] pp_d [2];
    logic [1:0]    ft_v [2];
    logic [1:0]    pp_v [2];

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R9";
    bit    done = 1'b0;

    dual_port_lane_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .a_clk(clk), .b_clk(clk), .rst_n(rst_n),
        .a_ce0_n(ce0_n[0]), .a_ce1(ce1[0]), .a_wr_n(wr_n[0]), .a_ub_n(ub_n[0]),
        .a_lb_n(lb_n[0]), .a_oe_n(oe_n[0]), .a_pipe(pipe[0]), .a_addr(addr[0]),
        .a_wdata(wdata[0]), .a_rdata(rdata[0]), .a_rvalid(rvalid[0]),
        .b_ce0_n(ce0_n[1]), .b_ce1(ce1[1]), .b_wr_n(wr_n[1]), .b_ub_n(ub_n[1]),
        .b_lb_n(lb_n[1]), .b_oe_n(oe_n[1]), .b_pipe(pipe[1]), .b_addr(addr[1]),
        .b_wdata(wdata[1]), .b_rdata(rdata[1]), .b_rvalid(rvalid[1])
    );

    task automatic set_idle(input int p);
        ce0_n[p] = 1'b1; ce1[p] = 1'b1; wr_n[p] = 1'b1;
        ub_n[p] = 1'b0; lb_n[p] = 1'b0; oe_n[p] = 1'b0;
        addr[p] = '0; wdata[p] = '0;
    endtask

    task automatic drv_write(input int p, input int a, input logic [DW-1:0] d,
                             input logic u_n, input logic l_n);
        ce0_n[p] = 1'b0; ce1[p] = 1'b1; wr_n[p] = 1'b0;
        ub_n[p] = u_n; lb_n[p] = l_n; addr[p] = AW'(a); wdata[p] = d;
    endtask

    task automatic drv_read(input int p, input int a, input logic u_n, input logic l_n);
        ce0_n[p] = 1'b0; ce1[p] = 1'b1; wr_n[p] = 1'b1;
        ub_n[p] = u_n; lb_n[p] = l_n; addr[p] = AW'(a);
    endtask

    // Reference behaviour at a rising edge: reads see the memory before writes.
    task automatic model_edge();
        logic [DW-1:0] nft_d [2];
        logic [1:0]    nft_v [2];
        logic [DW-1:0] npp_d [2];
        logic [1:0]    npp_v [2];
        for (int p = 0; p < 2; p++) begin
            logic s, rd;
            s  = !ce0_n[p] && ce1[p];
            rd = s && wr_n[p];
            nft_v[p] = {rd && !ub_n[p], rd && !lb_n[p]};
            nft_d[p] = ft_d[p];
            if (nft_v[p][1]) nft_d[p][15:8] = ref_mem[addr[p]][15:8];
            if (nft_v[p][0]) nft_d[p][7:0]  = ref_mem[addr[p]][7:0];
            npp_v[p] = ft_v[p] & {2{s}};
            npp_d[p] = ft_d[p];
        end
        for (int p = 0; p < 2; p++) begin
            if (!ce0_n[p] && ce1[p] && !wr_n[p]) begin
                if (!ub_n[p]) ref_mem[addr[p]][15:8] = wdata[p][15:8];
                if (!lb_n[p]) ref_mem[addr[p]][7:0]  = wdata[p][7:0];
            end
        end
        for (int p = 0; p < 2; p++) begin
            ft_d[p] = nft_d[p]; ft_v[p] = nft_v[p];
            pp_d[p] = npp_d[p]; pp_v[p] = npp_v[p];
        end
    endtask

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            logic [1:0]    ev;
            logic [DW-1:0] ed;
            ev = (pipe[p] ? pp_v[p] : ft_v[p]) & {2{!oe_n[p]}};
            ed = pipe[p] ? pp_d[p] : ft_d[p];
            n_cmp++;
            if (rvalid[p] !== ev || rdata[p] !== ed) begin
                n_bad++;
                $display("FAIL %s port %0d: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                         cur_req, p, rvalid[p], rdata[p], ev, ed);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic random_phase(input int cycles, input logic pa, input logic pb);
        pipe[0] = pa; pipe[1] = pb;
        for (int c = 0; c < cycles; c++) begin
            for (int p = 0; p < 2; p++) begin
                ce0_n[p] = ($urandom % 8) == 0;
                ce1[p]   = ($urandom % 8) != 0;
                wr_n[p]  = ($urandom % 2) == 0;
                ub_n[p]  = ($urandom % 4) == 0;
                lb_n[p]  = ($urandom % 4) == 0;
                oe_n[p]  = ($urandom % 10) == 0;
                addr[p]  = AW'($urandom % 16);
                wdata[p] = DW'($urandom);
            end
            if (!wr_n[0] && !wr_n[1] && addr[0] == addr[1]) wr_n[1] = 1'b1;
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        for (int p = 0; p < 2; p++) begin
            set_idle(p); pipe[p] = 1'b0;
            ft_d[p] = '0; pp_d[p] = '0; ft_v[p] = '0; pp_v[p] = '0;
        end
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R9"; compare();           // reset state
        // Read during reset shows nothing.
        drv_read(0, 0, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        compare();
        set_idle(0);
        rst_n = 1'b1;
        step();

        // R2: full word write then lane writes, read back on the other port.
        cur_req = "R2";
        drv_write(0, 5, 16'h1234, 1'b0, 1'b0); step();
        set_idle(0); drv_read(1, 5, 1'b0, 1'b0); step();
        drv_write(0, 5, 16'hAB77, 1'b0, 1'b1); set_idle(1); step();
        set_idle(0); drv_read(1, 5, 1'b0, 1'b0); step();    // expect AB34
        drv_write(0, 5, 16'h55CD, 1'b1, 1'b0); set_idle(1); step();
        set_idle(0); drv_read(1, 5, 1'b0, 1'b0); step();    // expect ABCD

        // R1: both kinds of deselect make writes no-ops and blank outputs.
        cur_req = "R1";
        drv_write(0, 5, 16'hFFFF, 1'b0, 1'b0); ce0_n[0] = 1'b1; set_idle(1); step();
        drv_write(0, 5, 16'hEEEE, 1'b0, 1'b0); ce1[0] = 1'b0; step();
        drv_read(0, 5, 1'b0, 1'b0); ce1[0] = 1'b0; step();
        drv_read(0, 5, 1'b0, 1'b0); step();                 // still ABCD

        // R3: lane-masked reads, write cycle blanks.
        cur_req = "R3";
        drv_read(0, 5, 1'b0, 1'b1); step();
        drv_read(0, 5, 1'b1, 1'b0); step();
        drv_read(0, 5, 1'b1, 1'b1); step();
        drv_write(0, 6, 16'h0F0F, 1'b0, 1'b0); step();

        // R8: no new read keeps the last data.
        cur_req = "R8";
        drv_read(0, 6, 1'b0, 1'b0); step();
        drv_read(0, 5, 1'b1, 1'b0); step();                 // upper lane keeps 0F
        set_idle(0); step();

        // R6: output enable acts without a clock edge.
        cur_req = "R6";
        drv_read(0, 5, 1'b0, 1'b0); step();
        set_idle(0); ce0_n[0] = 1'b0; oe_n[0] = 1'b1; #1; compare();
        oe_n[0] = 1'b0; #1; compare();
        set_idle(0);

        // R4: flow-through latency on the last address.
        cur_req = "R4";
        drv_write(1, DEPTH - 1, 16'hC3A5, 1'b0, 1'b0); step();
        set_idle(1); drv_read(0, DEPTH - 1, 1'b0, 1'b0); step();
        set_idle(0); step();

        // R7: same-edge write and read of one word returns the old value.
        cur_req = "R7";
        drv_write(0, 5, 16'h9966, 1'b0, 1'b0); drv_read(1, 5, 1'b0, 1'b0); step();
        set_idle(0); step();                                // now new value
        drv_read(0, 5, 1'b0, 1'b0); drv_read(1, 5, 1'b0, 1'b0); step();
        set_idle(0); set_idle(1); step();

        // R5: pipelined latency and the two-select reactivation rule.
        cur_req = "R5";
        pipe[1] = 1'b1;
        drv_read(1, 6, 1'b0, 1'b0); step();
        drv_read(1, 5, 1'b0, 1'b0); step();
        drv_read(1, DEPTH - 1, 1'b0, 1'b0); step();
        set_idle(1); step();                                // deselected: blank
        step();
        drv_read(1, 6, 1'b0, 1'b0); step();                 // first select
        step();                                             // second select: drives
        set_idle(1); pipe[1] = 1'b0; step();

        // Preload a small window for random traffic.
        cur_req = "R2";
        for (int i = 0; i < 16; i++) begin
            drv_write(0, i, DW'(i * 16'h1111 + 16'h0203), 1'b0, 1'b0); step();
        end
        set_idle(0);

        cur_req = "R4"; random_phase(1500, 1'b0, 1'b0);
        cur_req = "R5"; random_phase(1500, 1'b1, 1'b1);
        cur_req = "R7"; random_phase(1500, 1'b0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule